// File: doc/BRIEF.md
# Host Register Window for a Network Adapter

This block is the register file that a host processor sees through a small memory window on a network adapter. A single address carries three fields: a register offset, an operation code and an area selector. Each host access therefore says both which byte register it targets and what it does to it: overwrite it, AND a mask into it, OR a mask into it, or read it. Because the operation travels in the address, one store can set or clear a chosen group of bits with no read-modify-write sequence on the host side. Adapter-side logic posts events through set strobes. The block combines the pending status bits into a host interrupt. Any access that targets something that cannot be written raises a status bit of its own.

The control area holds these registers: the host and adapter interrupt status pairs, a shared-RAM base register, a RAM-size readback register, a paging register and plain byte storage for the timer and window registers. Two identification areas are read through an external lookup port. The remaining area is reserved.

Top module: `hreg_ctl`

## Requirements
- R1: After reset, every control register holds 0x00, and rd_valid, irq_o, chck_o, paging_en, ram_base and adp_req are all zero.
- R2: The operation is acc_addr[6:5]: 00 writes acc_wdata, 01 ANDs acc_wdata into the register, 10 ORs it into the register. The new value is visible from the clock edge that samples acc_valid. Control registers are offsets 0x00 to 0x11 of area 00 (acc_addr[8:7] = 00). Offsets 0x02 to 0x07, 0x0A, 0x0C to 0x0F and 0x11 behave as plain read/write bytes.
- R3: A read (acc_addr[6:5] = 11) sets rd_valid for exactly one cycle, on the clock edge after the access. rd_data then holds the value the register had before that edge. Without a read, rd_valid is 0.
- R4: Offset 0x00 bits 7:1 drive ram_base, and its bit 0 always reads 0. Offset 0x01 always reads {4'b0, ram_size, 2'b00}, where ram_size 00/01/10/11 means 8/16/32/64 KB. Host writes to offset 0x01 have no visible effect.
- R5: paging_en is 1 exactly when bits 7 and 6 of offset 0x10 are both 1, so writing 0xC0 enables paging.
- R6: In host status offset 0x08, ev_timer sets bit 4, ev_err sets bit 3, and an access violation sets bit 2. In host status offset 0x09, adp_set[k] sets bit k for k = 1 to 6. When a set and a host AND-clear of the same bit arrive in the same cycle, the bit ends up set.
- R7: A status bit is pending if it is offset 0x08 bit 4, 3 or 2, or offset 0x09 bit 6 to 1. irq_o is 1 when offset 0x08 bit 6 (enable) is 1, bit 7 is 1 and any bit is pending. chck_o is 1 under the same condition with bit 7 at 0. The two outputs are never 1 together, and both drop in the cycle after the pending bits are cleared.
- R8: An access violation is any of the following: an access of any operation to area 01, a write/AND/OR to area 00 at an offset of 0x12 or above, or a write/AND/OR to area 10 or 11. Reads of area 01 return 0x00.
- R9: Areas 10 and 11 are read-only. A read there returns id_rd_data, which was sampled during the access while id_index = {acc_addr[7], acc_addr[4:0]}.
- R10: Offset 0x0B drives adp_req. A 1 on adp_clr[k] clears bit k, applied after the host operation of the same cycle.
- R11: A read of area 00 at an offset of 0x12 or above returns 0x00 and does not set the violation bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_addr | input | 9 | Area [8:7], operation [6:5], offset [4:0] |
| acc_wdata | input | 8 | Data byte for write, AND and OR |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| id_index | output | 6 | Lookup index into the identification areas |
| id_rd_data | input | 8 | Identification byte for id_index |
| ram_size | input | 2 | Shared-RAM size code |
| ev_timer | input | 1 | Timer expiry set strobe |
| ev_err | input | 1 | Internal error set strobe |
| adp_set | input | 6 | Set strobes for host status odd bits 6:1 |
| adp_clr | input | 8 | Clear strobes for the adapter command register |
| ram_base | output | 7 | Shared-RAM base address bits 19:13 |
| paging_en | output | 1 | Shared-RAM paging enabled |
| adp_req | output | 8 | Adapter command register contents |
| irq_o | output | 1 | Host interrupt, normal mode |
| chck_o | output | 1 | Host interrupt, channel-check mode |

## Verification
The operation decode is tried with directed write, AND and OR sequences on one plain register. These show whether the three operations are told apart and whether each combines correctly with the old value. Set strobes that coincide with AND-clears of the same bit separate set-wins priority from clear-wins priority. Toggling the mode and enable bits shows the difference between the normal interrupt and channel-check gating. Random mixes of area, operation, offset and data, interleaved with random strobes, compare every read and every output against a bench model. This exposes wrong offset ranges, misclassified violations and readback errors on the special registers.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 9;
    localparam int OFS_W  = 5;
    localparam int NREG   = 18;
    localparam logic [OFS_W-1:0] NREG_L = OFS_W'(NREG);

    localparam logic [OFS_W-1:0] OFS_BASE   = 5'h00;
    localparam logic [OFS_W-1:0] OFS_SIZE   = 5'h01;
    localparam logic [OFS_W-1:0] OFS_HST_E  = 5'h08;
    localparam logic [OFS_W-1:0] OFS_HST_O  = 5'h09;
    localparam logic [OFS_W-1:0] OFS_ADP_O  = 5'h0B;
    localparam logic [OFS_W-1:0] OFS_PAGE   = 5'h10;

    localparam int HE_MODE = 7;
    localparam int HE_EN   = 6;
    localparam logic [DATA_W-1:0] HE_PEND_M = 8'h1C;
    localparam logic [DATA_W-1:0] HO_PEND_M = 8'h7E;

    typedef enum logic [1:0] {OP_WR = 2'b00, OP_AND = 2'b01, OP_OR = 2'b10, OP_RD = 2'b11} op_e;
    typedef enum logic [1:0] {AR_CTL = 2'b00, AR_RSV = 2'b01, AR_IDA = 2'b10, AR_IDB = 2'b11} area_e;
    typedef enum logic [1:0] {RK_REG, RK_SIZE, RK_ID, RK_ZERO} rdk_e;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]           rdata;
        logic                        rvalid;
    } st_t;
endpackage

// File: rtl/hreg_decode.sv
module hreg_decode
    import hreg_pkg::*;
(
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output op_e               op_o,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              mod_o,
    output logic              rd_o,
    output rdk_e              kind_o,
    output logic              viol_o
);
    area_e area;
    logic  in_map;
    logic  is_rd;

    always_comb begin
        area   = area_e'(acc_addr[8:7]);
        op_o   = op_e'(acc_addr[6:5]);
        ofs_o  = acc_addr[OFS_W-1:0];
        in_map = (ofs_o < NREG_L);
        is_rd  = (op_o == OP_RD);
        rd_o   = acc_valid && is_rd;
        mod_o  = acc_valid && !is_rd && (area == AR_CTL) && in_map;
        viol_o = acc_valid && ((area == AR_RSV) ||
                               (!is_rd && !((area == AR_CTL) && in_map)));
        unique case (area)
            AR_CTL:  kind_o = !in_map ? RK_ZERO :
                              (ofs_o == OFS_SIZE) ? RK_SIZE : RK_REG;
            AR_RSV:  kind_o = RK_ZERO;
            default: kind_o = RK_ID;
        endcase
    end
endmodule

// File: rtl/hreg_alu.sv
module hreg_alu
    import hreg_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] old_v,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] new_v
);
    always_comb begin
        unique case (op)
            OP_WR:   new_v = wdata;
            OP_AND:  new_v = old_v & wdata;
            OP_OR:   new_v = old_v | wdata;
            default: new_v = old_v;
        endcase
    end
endmodule

// File: rtl/hreg_irq.sv
module hreg_irq
    import hreg_pkg::*;
(
    input  logic [DATA_W-1:0] hst_even,
    input  logic [DATA_W-1:0] hst_odd,
    output logic              irq_o,
    output logic              chck_o
);
    logic pend;
    logic live;

    always_comb begin
        pend   = (|(hst_even & HE_PEND_M)) || (|(hst_odd & HO_PEND_M));
        live   = hst_even[HE_EN] && pend;
        irq_o  = live && hst_even[HE_MODE];
        chck_o = live && !hst_even[HE_MODE];
    end
endmodule

// File: rtl/hreg_ctl.sv
module hreg_ctl
    import hreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [OFS_W:0]    id_index,
    input  logic [DATA_W-1:0] id_rd_data,
    input  logic [1:0]        ram_size,
    input  logic              ev_timer,
    input  logic              ev_err,
    input  logic [6:1]        adp_set,
    input  logic [DATA_W-1:0] adp_clr,
    output logic [6:0]        ram_base,
    output logic              paging_en,
    output logic [DATA_W-1:0] adp_req,
    output logic              irq_o,
    output logic              chck_o
);
    st_t               st_d, st_q;
    op_e               op;
    logic [OFS_W-1:0]  ofs;
    logic              mod, rd, viol;
    rdk_e              kind;
    logic [DATA_W-1:0] old_sel, alu_y;
    logic [DATA_W-1:0] host_even_q;

    hreg_decode dec_i (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .op_o      (op),
        .ofs_o     (ofs),
        .mod_o     (mod),
        .rd_o      (rd),
        .kind_o    (kind),
        .viol_o    (viol)
    );

    hreg_alu alu_i (
        .op    (op),
        .old_v (old_sel),
        .wdata (acc_wdata),
        .new_v (alu_y)
    );

    hreg_irq irq_i (
        .hst_even (st_q.regs[OFS_HST_E]),
        .hst_odd  (st_q.regs[OFS_HST_O]),
        .irq_o    (irq_o),
        .chck_o   (chck_o)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        old_sel     = '0;
        if (ofs < NREG_L) begin
            old_sel = st_q.regs[ofs];
        end
        // host operation first, then adapter-side sets and clears
        if (mod) begin
            st_d.regs[ofs] = alu_y;
        end
        st_d.regs[OFS_BASE][0] = 1'b0;
        st_d.regs[OFS_HST_E] = st_d.regs[OFS_HST_E] |
                               {3'b000, ev_timer, ev_err, viol, 2'b00};
        st_d.regs[OFS_HST_O] = st_d.regs[OFS_HST_O] | {1'b0, adp_set, 1'b0};
        st_d.regs[OFS_ADP_O] = st_d.regs[OFS_ADP_O] & ~adp_clr;
        if (rd) begin
            st_d.rvalid = 1'b1;
            unique case (kind)
                RK_REG:  st_d.rdata = old_sel;
                RK_SIZE: st_d.rdata = {4'b0000, ram_size, 2'b00};
                RK_ID:   st_d.rdata = id_rd_data;
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign id_index    = {acc_addr[7], acc_addr[OFS_W-1:0]};
    assign rd_valid    = st_q.rvalid;
    assign rd_data     = st_q.rdata;
    assign ram_base    = st_q.regs[OFS_BASE][7:1];
    assign paging_en   = &st_q.regs[OFS_PAGE][7:6];
    assign adp_req     = st_q.regs[OFS_ADP_O];
    assign host_even_q = st_q.regs[OFS_HST_E];
endmodule

// File: rtl/hreg_ctl_chk.sv
module hreg_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [8:0] acc_addr,
    input logic       ev_timer,
    input logic [7:0] host_even,
    input logic       rd_valid,
    input logic       irq_o,
    input logic       chck_o,
    input logic [7:0] adp_clr,
    input logic [7:0] adp_req
);
    logic is_rd;
    logic host_on_req;
    assign is_rd       = acc_valid && (acc_addr[6:5] == 2'b11);
    assign host_on_req = acc_valid && (acc_addr[8:7] == 2'b00) &&
                         (acc_addr[4:0] == 5'h0B) && (acc_addr[6:5] != 2'b11);

    a_r3_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rd_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !rd_valid);
    a_r6_timer_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_timer |=> host_even[4]);
    a_r8_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[8:7] == 2'b01) |=> host_even[2]);
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && chck_o));
    a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || chck_o) |-> host_even[6]);
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((|adp_clr) && !host_on_req) |=> ((adp_req & $past(adp_clr)) == 8'h00));
endmodule

bind hreg_ctl hreg_ctl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .ev_timer  (ev_timer),
    .host_even (host_even_q),
    .rd_valid  (rd_valid),
    .irq_o     (irq_o),
    .chck_o    (chck_o),
    .adp_clr   (adp_clr),
    .adp_req   (adp_req)
);

// File: tb/hreg_ctl_tb_top.sv
module hreg_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [8:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [5:0] id_index;
    logic [7:0] id_rd_data;
    logic [1:0] ram_size = 2'b10;
    logic       ev_timer = 1'b0;
    logic       ev_err = 1'b0;
    logic [6:1] adp_set = '0;
    logic [7:0] adp_clr = '0;
    logic [6:0] ram_base;
    logic       paging_en;
    logic [7:0] adp_req;
    logic       irq_o, chck_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] mreg [18];

    always #10 clk = ~clk;

    function automatic logic [7:0] rom(input logic [5:0] idx);
        return {2'b01, idx} ^ 8'h3C;
    endfunction
    assign id_rd_data = rom(id_index);

    hreg_ctl dut_i (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] opf(input logic [1:0] op, input logic [7:0] o, input logic [7:0] w);
        case (op)
            2'b00:   return w;
            2'b01:   return o & w;
            2'b10:   return o | w;
            default: return o;
        endcase
    endfunction

    task automatic outs(input string tag);
        logic pend;
        pend = (|(mreg[8] & 8'h1C)) || (|(mreg[9] & 8'h7E));
        chk({tag, " R4 ram_base"}, {1'b0, ram_base}, {1'b0, mreg[0][7:1]});
        chk({tag, " R5 paging"}, {7'b0, paging_en}, {7'b0, mreg[16][7:6] == 2'b11});
        chk({tag, " R10 adp_req"}, adp_req, mreg[11]);
        chk({tag, " R7 irq"}, {7'b0, irq_o}, {7'b0, mreg[8][6] & pend & mreg[8][7]});
        chk({tag, " R7 chck"}, {7'b0, chck_o}, {7'b0, mreg[8][6] & pend & ~mreg[8][7]});
    endtask

    // one cycle: drive at negedge, model update, check at next negedge
    task automatic step(input logic acc, input logic [1:0] area, input logic [1:0] op,
                        input logic [4:0] ofs, input logic [7:0] wd);
        logic [7:0] exp_rd;
        logic       viol;
        logic       inmap;
        acc_valid = acc;
        acc_addr  = {area, op, ofs};
        acc_wdata = wd;
        inmap = (ofs < 5'd18);
        exp_rd = 8'h00;
        if (area == 2'b00 && inmap) exp_rd = (ofs == 5'd1) ? {4'b0, ram_size, 2'b00} : mreg[ofs];
        else if (area[1]) exp_rd = rom({area[0], ofs});
        viol = acc && (area == 2'b01 || (op != 2'b11 && !(area == 2'b00 && inmap)));
        @(posedge clk);
        @(negedge clk);
        if (acc && op != 2'b11 && area == 2'b00 && inmap) mreg[ofs] = opf(op, mreg[ofs], wd);
        mreg[0][0] = 1'b0;
        mreg[8] = mreg[8] | {3'b0, ev_timer, ev_err, viol, 2'b00};
        mreg[9] = mreg[9] | {1'b0, adp_set, 1'b0};
        mreg[11] = mreg[11] & ~adp_clr;
        if (acc && op == 2'b11) begin
            chk("R3 rd_valid", {7'b0, rd_valid}, 8'h01);
            chk("R3 rd_data", rd_data, exp_rd);
        end else begin
            chk("R3 idle rd_valid", {7'b0, rd_valid}, 8'h00);
        end
        outs("step");
        acc_valid = 1'b0;
        ev_timer = 1'b0; ev_err = 1'b0; adp_set = '0; adp_clr = '0;
    endtask

    task automatic rd_expect(input string tag, input logic [1:0] area, input logic [4:0] ofs,
                             input logic [7:0] exp);
        step(1'b1, area, 2'b11, ofs, 8'h00);
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        foreach (mreg[i]) mreg[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
        chk("R1 irq", {6'b0, irq_o, chck_o}, 8'h00);
        chk("R1 ram_base", {1'b0, ram_base}, 8'h00);
        chk("R1 paging", {7'b0, paging_en}, 8'h00);
        chk("R1 adp_req", adp_req, 8'h00);
        rd_expect("R1 reg8 zero", 2'b00, 5'h08, 8'h00);
        // R2 operations
        step(1'b1, 2'b00, 2'b00, 5'h02, 8'hA5);
        rd_expect("R2 write", 2'b00, 5'h02, 8'hA5);
        step(1'b1, 2'b00, 2'b01, 5'h02, 8'h0F);
        rd_expect("R2 and", 2'b00, 5'h02, 8'h05);
        step(1'b1, 2'b00, 2'b10, 5'h02, 8'hF0);
        rd_expect("R2 or", 2'b00, 5'h02, 8'hF5);
        // R3 single-cycle valid
        step(1'b0, 2'b00, 2'b11, 5'h02, 8'h00);
        chk("R3 pulse ends", {7'b0, rd_valid}, 8'h00);
        // R4 relocation and size
        step(1'b1, 2'b00, 2'b00, 5'h00, 8'hFF);
        chk("R4 base out", {1'b0, ram_base}, 8'h7F);
        rd_expect("R4 bit0 zero", 2'b00, 5'h00, 8'hFE);
        rd_expect("R4 size", 2'b00, 5'h01, 8'h08);
        step(1'b1, 2'b00, 2'b00, 5'h01, 8'hFF);
        rd_expect("R4 size ignores write", 2'b00, 5'h01, 8'h08);
        // R5 paging
        step(1'b1, 2'b00, 2'b00, 5'h10, 8'hC0);
        chk("R5 on", {7'b0, paging_en}, 8'h01);
        step(1'b1, 2'b00, 2'b00, 5'h10, 8'h80);
        chk("R5 off", {7'b0, paging_en}, 8'h00);
        // R6 / R7 interrupt
        step(1'b1, 2'b00, 2'b00, 5'h08, 8'hC0);
        chk("R7 no pending", {7'b0, irq_o}, 8'h00);
        ev_timer = 1'b1;
        step(1'b0, 2'b00, 2'b00, 5'h00, 8'h00);
        chk("R7 irq on", {6'b0, irq_o, chck_o}, 8'h02);
        rd_expect("R6 timer bit", 2'b00, 5'h08, 8'hD0);
        step(1'b1, 2'b00, 2'b01, 5'h08, 8'hEF);
        chk("R7 irq cleared", {6'b0, irq_o, chck_o}, 8'h00);
        ev_err = 1'b1;
        step(1'b1, 2'b00, 2'b01, 5'h08, 8'hF7);
        rd_expect("R6 set wins", 2'b00, 5'h08, 8'hC8);
        chk("R7 irq err", {7'b0, irq_o}, 8'h01);
        step(1'b1, 2'b00, 2'b01, 5'h08, 8'hE3);
        step(1'b1, 2'b00, 2'b00, 5'h08, 8'h40);
        adp_set = 6'b010000;
        step(1'b0, 2'b00, 2'b00, 5'h00, 8'h00);
        chk("R7 chck mode", {6'b0, irq_o, chck_o}, 8'h01);
        rd_expect("R6 odd bit5", 2'b00, 5'h09, 8'h20);
        step(1'b1, 2'b00, 2'b00, 5'h08, 8'h00);
        chk("R7 disabled", {6'b0, irq_o, chck_o}, 8'h00);
        step(1'b1, 2'b00, 2'b00, 5'h09, 8'h00);
        // R8 violations
        step(1'b1, 2'b00, 2'b00, 5'h15, 8'h55);
        rd_expect("R8 bad offset", 2'b00, 5'h08, 8'h04);
        step(1'b1, 2'b00, 2'b01, 5'h08, 8'h00);
        rd_expect("R8 reserved read zero", 2'b01, 5'h03, 8'h00);
        rd_expect("R8 reserved flag", 2'b00, 5'h08, 8'h04);
        step(1'b1, 2'b00, 2'b01, 5'h08, 8'h00);
        step(1'b1, 2'b10, 2'b00, 5'h03, 8'h11);
        rd_expect("R8 id write flag", 2'b00, 5'h08, 8'h04);
        step(1'b1, 2'b00, 2'b01, 5'h08, 8'h00);
        // R11 invalid offset read
        rd_expect("R11 read zero", 2'b00, 5'h1F, 8'h00);
        rd_expect("R11 no flag", 2'b00, 5'h08, 8'h00);
        // R9 identification areas
        rd_expect("R9 area A", 2'b10, 5'h03, rom(6'h03));
        rd_expect("R9 area B", 2'b11, 5'h07, rom(6'h27));
        // R10 adapter request register
        step(1'b1, 2'b00, 2'b10, 5'h0B, 8'h30);
        chk("R10 set", adp_req, 8'h30);
        adp_clr = 8'h10;
        step(1'b0, 2'b00, 2'b00, 5'h00, 8'h00);
        chk("R10 clr", adp_req, 8'h20);
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom();
            if (r[3:0] == 4'h0) ev_timer = 1'b1;
            if (r[7:4] == 4'h1) ev_err = 1'b1;
            if (r[11:8] == 4'h2) adp_set = 6'($urandom());
            if (r[15:12] == 4'h3) adp_clr = 8'($urandom());
            step(r[16] | r[17], (r[20:18] == 3'b000) ? r[22:21] : 2'b00,
                 r[24:23], (r[25] ? r[30:26] : {1'b0, r[29:26]}), 8'($urandom()));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule